// File: doc/BRIEF.md
# Overlay plane compositor

This block places a second picture plane on top of the main display stream, one pixel per clock. Each cycle it takes a main pixel in RGB555, a 16-bit overlay word, and the number of the scan line being produced. Within a programmable band of lines, it combines the two pixels according to a selected overlay format. Outside that band, or when the overlay is switched off, the main pixel goes through untouched.

Two of the formats carry transparency inside each overlay pixel. One uses a 4-bit alpha to weight a blend; the other uses a single bit to choose between the two pixels. The third format has no alpha field: an overlay pixel that equals a programmed RGB555 key is treated as transparent. Fetching the overlay and generating its addresses are left to neighbouring logic.

The composed pixel is registered and leaves one cycle after its inputs, together with a valid flag.

Top module: `ovl_compositor`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0 and `out_px` is 0.
- R2: `out_valid` is `in_valid` delayed by one clock. `out_px` takes a new value only in the cycle after `in_valid` was 1, and holds its value otherwise.
- R3: When `ovl_en` is 0, the result is `main_px`, whatever the other inputs are.
- R4: The overlay acts only when `line_start <= line_num <= line_end`, with both limits inclusive. On any other line the result is `main_px`, and if `line_start > line_end` no line is overlaid.
- R5: For `ovl_fmt` = 01, the overlay word is R[15:11], G[10:6], B[5:1] and alpha bit [0]. If alpha is 1 the result is `ovl_px[15:1]`; if alpha is 0 the result is `main_px`.
- R6: For `ovl_fmt` = 00, the overlay word is R[15:12], G[11:8], B[7:4] and alpha A[3:0]. Each overlay channel is widened to 5 bits as {c, c[3]}. Each output channel is (m*(15-A) + o*A + 7) / 15, using integer division. An alpha of 15 gives the widened overlay and an alpha of 0 gives the main pixel.
- R7: For `ovl_fmt` = 10, the overlay colour is `ovl_px[14:0]` and bit 15 is ignored. If this colour equals `key`, the result is `main_px`; otherwise the result is `ovl_px[14:0]`.
- R8: For `ovl_fmt` = 11, the result is `main_px`.
- R9: Pixels in RGB555 are laid out as R[14:10], G[9:5], B[4:0]. Blending is done on each channel on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel qualifier |
| main_px | input | 15 | Main plane pixel, RGB555 |
| ovl_px | input | 16 | Overlay word, layout set by format |
| line_num | input | LINE_W | Current scan line |
| ovl_en | input | 1 | Overlay on |
| ovl_fmt | input | 2 | Overlay format: 00 alpha4, 01 alpha1, 10 keyed, 11 off |
| key | input | 15 | Transparent colour for keyed format |
| line_start | input | LINE_W | First overlaid line |
| line_end | input | LINE_W | Last overlaid line |
| out_valid | output | 1 | Result qualifier |
| out_px | output | 15 | Composed pixel, RGB555 |

## Verification
The line window test and the per-pixel transparency decision act on the same pixel. On the first and last lines of the band, both can decide the outcome in the same cycle. The bench drives a key-matching pixel and an opaque pixel exactly on `line_start` and `line_end`, and also one line outside each limit. A scoreboard model predicts each result, so a window that is off by one line shows up as a mismatch. Back-to-back pixels that mix formats and lines are interleaved with idle gaps. These check that each result lines up with its own inputs, and that the output is held while no input is valid.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
   localparam int CH_W  = 5;
   localparam int PIX_W = 3 * CH_W;
   localparam int OVL_W = 16;

   typedef enum logic [1:0] {
      FMT_ALPHA4 = 2'b00,
      FMT_ALPHA1 = 2'b01,
      FMT_KEYED  = 2'b10,
      FMT_OFF    = 2'b11
   } ovl_fmt_e;
endpackage

// File: rtl/ovl_window.sv
module ovl_window #(
   parameter int LINE_W = 11
) (
   input  logic [LINE_W-1:0] line_num,
   input  logic [LINE_W-1:0] line_start,
   input  logic [LINE_W-1:0] line_end,
   output logic              hit
);
   // Both limits are inclusive; an inverted range yields no hit
   always_comb hit = (line_num >= line_start) && (line_num <= line_end);
endmodule

// File: rtl/ovl_blend4.sv
module ovl_blend4
   import ovl_pkg::*;
#(
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic [PIX_W-1:0] main_px,
   input  logic [OVL_W-1:0] ovl_px,
   output logic [PIX_W-1:0] mix_px
);
   localparam int SUM_W = 10;

   logic [3:0]       alpha;
   logic [3:0]       inv;
   logic [SUM_W-1:0] rnd;

   assign alpha = ovl_px[3:0];
   assign inv   = 4'd15 - alpha;

   generate
      if (ROUND_NEAREST) begin : g_round
         assign rnd = SUM_W'(7);
      end else begin : g_trunc
         assign rnd = '0;
      end
   endgenerate

   // channel c: main bits [c*5 +: 5], overlay nibble [4+c*4 +: 4]
   for (genvar c = 0; c < 3; c++) begin : g_ch
      logic [CH_W-1:0]  m;
      logic [3:0]       o4;
      logic [CH_W-1:0]  o5;
      logic [SUM_W-1:0] acc;
      logic [SUM_W-1:0] q;
      assign m   = main_px[c*CH_W +: CH_W];
      assign o4  = ovl_px[4 + c*4 +: 4];
      assign o5  = {o4, o4[3]};
      assign acc = SUM_W'(m) * SUM_W'(inv) + SUM_W'(o5) * SUM_W'(alpha) + rnd;
      assign q   = acc / SUM_W'(15);
      assign mix_px[c*CH_W +: CH_W] = q[CH_W-1:0];
   end
endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
   import ovl_pkg::*;
#(
   parameter int LINE_W        = 11,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [14:0]       main_px,
   input  logic [15:0]       ovl_px,
   input  logic [LINE_W-1:0] line_num,
   input  logic              ovl_en,
   input  logic [1:0]        ovl_fmt,
   input  logic [14:0]       key,
   input  logic [LINE_W-1:0] line_start,
   input  logic [LINE_W-1:0] line_end,
   output logic              out_valid,
   output logic [14:0]       out_px
);
   generate
      if (LINE_W < 2 || LINE_W > 16) begin : g_bad_line_w
         $error("ovl_compositor: LINE_W out of range");
      end
   endgenerate

   logic             in_band;
   logic [PIX_W-1:0] blend_px;
   logic [PIX_W-1:0] comp_px;
   ovl_fmt_e         fmt;

   assign fmt = ovl_fmt_e'(ovl_fmt);

   ovl_window #(.LINE_W(LINE_W)) u_win (
      .line_num  (line_num),
      .line_start(line_start),
      .line_end  (line_end),
      .hit       (in_band)
   );

   ovl_blend4 #(.ROUND_NEAREST(ROUND_NEAREST)) u_blend (
      .main_px(main_px),
      .ovl_px (ovl_px),
      .mix_px (blend_px)
   );

   always_comb begin
      comp_px = main_px;
      if (ovl_en && in_band) begin
         unique case (fmt)
            FMT_ALPHA4: comp_px = blend_px;
            FMT_ALPHA1: comp_px = ovl_px[0] ? ovl_px[15:1] : main_px;
            FMT_KEYED:  comp_px = (ovl_px[14:0] == key) ? main_px : ovl_px[14:0];
            default:    comp_px = main_px;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_px    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_px <= comp_px;
      end
   end

   assert_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_px)));
   assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !ovl_en) |=> out_px == $past(main_px));
   assert_below_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && line_num < line_start) |=> out_px == $past(main_px));
   assert_clear_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ovl_fmt == 2'b01 && !ovl_px[0]) |=> out_px == $past(main_px));
   assert_opaque_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ovl_en && ovl_fmt == 2'b00 && ovl_px[3:0] == 4'hF &&
       line_num >= line_start && line_num <= line_end)
      |=> out_px == $past({ovl_px[15:12], ovl_px[15], ovl_px[11:8], ovl_px[11],
                           ovl_px[7:4], ovl_px[7]}));
   assert_key_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ovl_fmt == 2'b10 && ovl_px[14:0] == key) |=> out_px == $past(main_px));
   assert_fmt_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ovl_fmt == 2'b11) |=> out_px == $past(main_px));
endmodule

// File: tb/sim_ovl_compositor.sv
module sim_ovl_compositor;
   localparam int LW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [14:0]   main_px = '0;
   logic [15:0]   ovl_px = '0;
   logic [LW-1:0] line_num = '0;
   logic          ovl_en = 1'b0;
   logic [1:0]    ovl_fmt = '0;
   logic [14:0]   key = '0;
   logic [LW-1:0] line_start = '0;
   logic [LW-1:0] line_end = '0;
   logic          out_valid;
   logic [14:0]   out_px;

   int checks = 0;
   int errors = 0;
   logic [14:0] exp_q[$];
   string       tag_q[$];
   logic [14:0] last_px = '0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   ovl_compositor #(.LINE_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .main_px(main_px),
      .ovl_px(ovl_px), .line_num(line_num), .ovl_en(ovl_en), .ovl_fmt(ovl_fmt),
      .key(key), .line_start(line_start), .line_end(line_end),
      .out_valid(out_valid), .out_px(out_px)
   );

   function automatic logic [14:0] model(logic [14:0] m, logic [15:0] o, int ln,
                                         bit en, logic [1:0] f, logic [14:0] k,
                                         int s, int e);
      logic [14:0] r;
      if (!en || ln < s || ln > e) return m;
      case (f)
         2'b00: begin
            for (int c = 0; c < 3; c++) begin
               int mc = int'(m[c*5 +: 5]);
               int oc = int'({o[4+c*4 +: 4], o[7+c*4]});
               int a  = int'(o[3:0]);
               r[c*5 +: 5] = 5'((mc * (15 - a) + oc * a + 7) / 15);
            end
            return r;
         end
         2'b01:   return o[0] ? o[15:1] : m;
         2'b10:   return (o[14:0] == k) ? m : o[14:0];
         default: return m;
      endcase
   endfunction

   task automatic check(string req, logic [14:0] act, logic [14:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic push(string req, logic [14:0] m, logic [15:0] o, int ln, bit en,
                       logic [1:0] f, logic [14:0] k, int s, int e);
      main_px = m; ovl_px = o; line_num = LW'(ln); ovl_en = en; ovl_fmt = f;
      key = k; line_start = LW'(s); line_end = LW'(e); in_valid = 1'b1;
      exp_q.push_back(model(m, o, ln, en, f, k, s, e));
      tag_q.push_back(req);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic idle(int n);
      in_valid = 1'b0;
      main_px = 15'h5A5A; ovl_px = 16'hFFFF;
      repeat (n) @(negedge clk);
   endtask

   // monitor: samples on the falling edge, one edge after the driver
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check("R2 unexpected valid", out_px, 15'h0);
               errors++;
            end else begin
               logic [14:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, out_px, e);
            end
         end else begin
            check("R2 hold", out_px, last_px);
         end
         last_px = out_px;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset px", out_px, 15'h0);
      check("R1 reset valid", 15'(out_valid), 15'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 post-reset valid", 15'(out_valid), 15'h0);
      // R3 disabled overlay passes main
      push("R3", 15'h1234, 16'hABCD, 20, 1'b0, 2'b10, 15'h0, 10, 30);
      push("R3", 15'h7FFF, 16'h0001, 20, 1'b0, 2'b01, 15'h0, 10, 30);
      // R8 reserved format
      push("R8", 15'h2222, 16'hFFFF, 20, 1'b1, 2'b11, 15'h0, 10, 30);
      // R5 single alpha bit
      push("R5 on", 15'h0F0F, 16'hA5A5, 20, 1'b1, 2'b01, 15'h0, 10, 30);
      push("R5 off", 15'h0F0F, 16'hA5A4, 20, 1'b1, 2'b01, 15'h0, 10, 30);
      idle(2);
      // R6 blend: opaque, clear, half, rounding
      push("R6 a15", 15'h0000, 16'h9C6F, 20, 1'b1, 2'b00, 15'h0, 10, 30);
      push("R6 a0", 15'h3BCD, 16'hFFF0, 20, 1'b1, 2'b00, 15'h0, 10, 30);
      push("R6 a8", 15'h7FFF, 16'h0008, 20, 1'b1, 2'b00, 15'h0, 10, 30);
      push("R6 a1", 15'h0000, 16'hFFF1, 20, 1'b1, 2'b00, 15'h0, 10, 30);
      push("R9 chan", 15'h7C00, 16'h0F07, 20, 1'b1, 2'b00, 15'h0, 10, 30);
      // R7 keyed
      push("R7 hit", 15'h1111, 16'h2345, 20, 1'b1, 2'b10, 15'h2345, 10, 30);
      push("R7 miss", 15'h1111, 16'h2346, 20, 1'b1, 2'b10, 15'h2345, 10, 30);
      push("R7 bit15", 15'h1111, 16'hA345, 20, 1'b1, 2'b10, 15'h2345, 10, 30);
      idle(3);
      // R4 band edges combined with transparency decisions
      push("R4 start key", 15'h0101, 16'h4444, 10, 1'b1, 2'b10, 15'h4444, 10, 30);
      push("R4 start opaque", 15'h0101, 16'h4445, 10, 1'b1, 2'b10, 15'h4444, 10, 30);
      push("R4 before", 15'h0101, 16'h4445, 9, 1'b1, 2'b10, 15'h4444, 10, 30);
      push("R4 end key", 15'h0202, 16'h4444, 30, 1'b1, 2'b10, 15'h4444, 10, 30);
      push("R4 end opaque", 15'h0202, 16'h0003, 30, 1'b1, 2'b01, 15'h4444, 10, 30);
      push("R4 after", 15'h0202, 16'h0003, 31, 1'b1, 2'b01, 15'h4444, 10, 30);
      push("R4 inverted", 15'h0303, 16'hFFFF, 20, 1'b1, 2'b01, 15'h0, 30, 10);
      push("R4 single", 15'h0303, 16'hFFFF, 7, 1'b1, 2'b01, 15'h0, 7, 7);
      push("R4 top", 15'h0303, 16'hFFFF, 2047, 1'b1, 2'b01, 15'h0, 2040, 2047);
      idle(1);
      // mixed random stream, R6 and the others
      for (int i = 0; i < 60; i++) begin
         push("R6 mix", 15'($urandom), 16'($urandom), int'($urandom_range(0, 40)),
              1'($urandom), 2'($urandom), 15'($urandom), 5, 35);
         if (i % 7 == 0) idle(2);
      end
      idle(3);
      if (exp_q.size() != 0) check("R2 drain", 15'(exp_q.size()), 15'h0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule